// File: doc/BRIEF.md
# Quasi-Bidirectional Port Drive Control

This block produces the pad controls for a bank of quasi-bidirectional pins that have no direction register. Each pin has one output latch bit. When the bit is 0 the pin is pulled hard to ground. When the bit is 1 only a weak pull-up holds the pin high, so an outside driver can pull the pin low and the pin serves as an input. A byte written to the port also turns on a short strong pull-up on every bit written as 1. This gives a fast rising edge into a heavy load. The strong pull-up ends at the next falling edge of the serial clock.

The serial front end supplies three single-cycle strobes in the core clock domain: a write strobe that carries the received byte, a read strobe, and a strobe for the serial-clock falling edge. On the read strobe, the pin levels pass through a synchronizer and are captured into an input latch. That latch is visible at the block's output so that a change detector elsewhere can use it. The pad is modelled only by its three enable outputs per bit.

Top module: `qbp_port_drive`

## Requirements
- R1: After synchronous active-low reset, every output latch bit is 1 (`port_q` = all ones), `weak_pu_en` is all ones, and `drive_low_en` and `strong_pu_en` are all zeros. The input latch `in_q` is all ones.
- R2: A cycle with `wr_stb` high loads `wr_byte` into `port_q` at the next clock edge. For each bit i, `drive_low_en[i]` is the inverse of `port_q[i]` and `weak_pu_en[i]` equals `port_q[i]`.
- R3: After a write, `strong_pu_en` equals the written byte. Bits written as 1 get the strong pull-up, and bits written as 0 never get it. A write of 1 over a bit that already holds 1 turns the strong pull-up on again.
- R4: A cycle with `scl_fall` high and `wr_stb` low clears every bit of `strong_pu_en` at the next edge. `port_q` is left unchanged.
- R5: When `wr_stb` and `scl_fall` are high in the same cycle, the write wins: `strong_pu_en` becomes the new byte.
- R6: No bit ever has `drive_low_en` high together with `weak_pu_en` or `strong_pu_en`.
- R7: Without `wr_stb`, `port_q` holds its value, and no bit of `strong_pu_en` goes from 0 to 1.
- R8: `pin_lvl` passes through SYNC_STAGES (default 2) registers. A cycle with `rd_stb` high loads the synchronizer's last stage into `in_q` at the next edge. In the other cycles `in_q` holds its value. With the default depth, a pin change made in the same cycle as the read strobe is not captured. A pin value held for two edges before the strobe is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe: a complete byte was written to the port |
| wr_byte | input | PORT_W | Byte to load into the output latch |
| scl_fall | input | 1 | One-cycle strobe on the serial-clock falling edge |
| rd_stb | input | 1 | One-cycle strobe: capture the pin levels |
| pin_lvl | input | PORT_W | Asynchronous pin levels seen at the pads |
| port_q | output | PORT_W | Output latch contents |
| drive_low_en | output | PORT_W | Per-bit strong pull-down enable |
| weak_pu_en | output | PORT_W | Per-bit weak current-source pull-up enable |
| strong_pu_en | output | PORT_W | Per-bit momentary strong pull-up enable |
| in_q | output | PORT_W | Captured input levels, also fed to the change detector |

## Verification
Two things can land in the same cycle: a byte write and the serial-clock falling edge that would end the strong pull-up. The bench drives both strobes together on purpose, and it also drives them together at random. Each time, it expects the strong pull-up to match the new byte rather than be cleared. A read strobe that meets a write, or that comes in the same cycle as a pin change, is checked against the synchronizer latency the bench models. That latency decides whether the old or the new pin value is captured.

// File: rtl/qbp_pkg.sv
// Shared types for the quasi-bidirectional port drive control.
// Assumes: nothing beyond a single clock domain for all users.
package qbp_pkg;

    // Action applied to the strong pull-up register in one cycle.
    typedef enum logic [1:0] {
        SP_HOLD   = 2'd0,
        SP_ARM    = 2'd1,
        SP_DISARM = 2'd2
    } sp_evt_e;

    // Default port width and synchronizer depth.
    localparam int unsigned DEF_PORT_W = 8;
    localparam int unsigned DEF_SYNC   = 2;

endpackage

// File: rtl/qbp_out_latch.sv
// Output latch and strong pull-up arming register.
// What it does: loads the written byte on the write strobe and arms the
// strong pull-up for the bits written as 1. It disarms them on the
// serial-clock falling-edge strobe. A write in the same cycle wins.
// Assumes: strobes last one cycle and belong to the clk domain.
module qbp_out_latch
    import qbp_pkg::*;
#(
    parameter int unsigned PORT_W = DEF_PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [PORT_W-1:0] wr_byte,
    input  logic              scl_fall,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] boost_q
);

    sp_evt_e evt;

    // Pick the strong pull-up action; a write has priority over disarm.
    always_comb begin
        if (wr_stb)        evt = SP_ARM;
        else if (scl_fall) evt = SP_DISARM;
        else               evt = SP_HOLD;
    end

    // Output latch: all ones at reset, loaded only by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '1;
        else if (wr_stb) latch_q <= wr_byte;
    end

    // Strong pull-up register: arm on written ones, clear on disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boost_q <= '0;
        end else begin
            case (evt)
                SP_ARM:    boost_q <= wr_byte;
                SP_DISARM: boost_q <= '0;
                default:   boost_q <= boost_q;
            endcase
        end
    end

endmodule

// File: rtl/qbp_in_capture.sv
// Pin synchronizer and input latch.
// What it does: passes the asynchronous pin levels through SYNC_STAGES
// flops, then captures the last stage into the input latch on the read
// strobe.
// Assumes: SYNC_STAGES >= 1. The pins idle high, so the flops reset to ones.
module qbp_in_capture
    import qbp_pkg::*;
#(
    parameter int unsigned PORT_W      = DEF_PORT_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [PORT_W-1:0] pin_lvl,
    output logic [PORT_W-1:0] cap_q
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [PORT_W-1:0] stage [SYNC_STAGES];

    // First synchronizer stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '1;
        else        stage[0] <= pin_lvl;
    end

    // Remaining synchronizer stages, one flop row each.
    for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) stage[k] <= '1;
            else        stage[k] <= stage[k-1];
        end
    end

    // Input latch: captures the synchronized levels on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= '1;
        else if (rd_stb) cap_q <= stage[LAST];
    end

endmodule

// File: rtl/qbp_pad_ctrl.sv
// Per-bit pad enable decode.
// What it does: turns each latch bit and its boost bit into three pad
// enables. A 0 pulls hard low. A 1 keeps the weak pull-up, plus the
// strong pull-up while boost is set.
// Assumes: purely combinational; the inputs are registered upstream.
module qbp_pad_ctrl
    import qbp_pkg::*;
#(
    parameter int unsigned PORT_W = DEF_PORT_W
) (
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] boost_q,
    output logic [PORT_W-1:0] drive_low_en,
    output logic [PORT_W-1:0] weak_pu_en,
    output logic [PORT_W-1:0] strong_pu_en
);

    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        // Decode one pin: the pull-down and the pull-ups stay exclusive.
        always_comb begin
            drive_low_en[i] = ~latch_q[i];
            weak_pu_en[i]   =  latch_q[i];
            strong_pu_en[i] =  latch_q[i] & boost_q[i];
        end
    end

endmodule

// File: rtl/qbp_port_drive.sv
// Top of the quasi-bidirectional port drive control.
// What it does: ties the output latch, the input capture and the pad
// decode together. There is no direction register: a pin is an input
// while its latch bit is 1.
// Assumes: all strobes are single-cycle pulses in the clk domain.
module qbp_port_drive
    import qbp_pkg::*;
#(
    parameter int unsigned PORT_W      = DEF_PORT_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [PORT_W-1:0] wr_byte,
    input  logic              scl_fall,
    input  logic              rd_stb,
    input  logic [PORT_W-1:0] pin_lvl,
    output logic [PORT_W-1:0] port_q,
    output logic [PORT_W-1:0] drive_low_en,
    output logic [PORT_W-1:0] weak_pu_en,
    output logic [PORT_W-1:0] strong_pu_en,
    output logic [PORT_W-1:0] in_q
);

    logic [PORT_W-1:0] boost_q;

    qbp_out_latch #(.PORT_W(PORT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_byte  (wr_byte),
        .scl_fall (scl_fall),
        .latch_q  (port_q),
        .boost_q  (boost_q)
    );

    qbp_in_capture #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .pin_lvl (pin_lvl),
        .cap_q   (in_q)
    );

    qbp_pad_ctrl #(.PORT_W(PORT_W)) u_pad (
        .latch_q      (port_q),
        .boost_q      (boost_q),
        .drive_low_en (drive_low_en),
        .weak_pu_en   (weak_pu_en),
        .strong_pu_en (strong_pu_en)
    );

endmodule

// File: rtl/qbp_port_drive_chk.sv
// Property checker for qbp_port_drive, attached with bind.
// Assumes: the same clock and synchronous active-low reset as the top.
module qbp_port_drive_chk #(
    parameter int unsigned PORT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [PORT_W-1:0] wr_byte,
    input logic              scl_fall,
    input logic              rd_stb,
    input logic [PORT_W-1:0] port_q,
    input logic [PORT_W-1:0] drive_low_en,
    input logic [PORT_W-1:0] weak_pu_en,
    input logic [PORT_W-1:0] strong_pu_en,
    input logic [PORT_W-1:0] in_q
);

    // R1: the cycle after reset is held, the port is released and idle
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (port_q == '1 && strong_pu_en == '0 && in_q == '1));

    // R2: a write loads the byte
    p_wr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> port_q == $past(wr_byte));

    // R3: the strong pull-up follows exactly the ones just written
    p_boost_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> strong_pu_en == $past(wr_byte));

    // R4: a falling edge without a write clears every strong pull-up
    p_boost_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && !wr_stb) |=> strong_pu_en == '0);

    // R5: a write and a falling edge together leave the new byte armed
    p_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && wr_stb) |=> strong_pu_en == $past(wr_byte));

    // R6: the pull-down never meets a pull-up on the same bit
    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low_en & (weak_pu_en | strong_pu_en)) == '0);

    // R7: with no write, the latch holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(port_q));

    // R7: with no write, no strong pull-up bit turns on
    p_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> (strong_pu_en & ~$past(strong_pu_en)) == '0);

    // R8: the input latch only moves on a read strobe
    p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(in_q));

endmodule

bind qbp_port_drive qbp_port_drive_chk #(.PORT_W(PORT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_stb       (wr_stb),
    .wr_byte      (wr_byte),
    .scl_fall     (scl_fall),
    .rd_stb       (rd_stb),
    .port_q       (port_q),
    .drive_low_en (drive_low_en),
    .weak_pu_en   (weak_pu_en),
    .strong_pu_en (strong_pu_en),
    .in_q         (in_q)
);

// File: tb/qbp_port_drive_test.sv
// Bench for qbp_port_drive: a behavioural model updated on every rising
// edge, compared on every falling edge, plus directed checks.
module qbp_port_drive_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_stb = 1'b0, scl_fall = 1'b0, rd_stb = 1'b0;
    logic [W-1:0] wr_byte = '0, pin_lvl = '1;
    logic [W-1:0] port_q, drive_low_en, weak_pu_en, strong_pu_en, in_q;

    int total = 0;
    int bad   = 0;
    bit cmp_on = 1'b0;

    // 125 MHz clock
    always #4 clk = ~clk;

    qbp_port_drive #(.PORT_W(W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .scl_fall(scl_fall), .rd_stb(rd_stb), .pin_lvl(pin_lvl),
        .port_q(port_q), .drive_low_en(drive_low_en), .weak_pu_en(weak_pu_en),
        .strong_pu_en(strong_pu_en), .in_q(in_q)
    );

    // Reference model state
    logic [W-1:0] m_latch, m_boost, m_in;
    logic [W-1:0] m_sync[$];

    initial begin
        m_latch = '1; m_boost = '0; m_in = '1;
        m_sync = {8'hFF, 8'hFF};
    end

    // Model: behaviour on each rising edge, from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_latch = '1; m_boost = '0; m_in = '1;
            m_sync = {8'hFF, 8'hFF};
        end else begin
            if (rd_stb) m_in = m_sync[1];
            m_sync.push_front(pin_lvl);
            void'(m_sync.pop_back());
            if (wr_stb) begin
                m_latch = wr_byte;
                m_boost = wr_byte;
            end else if (scl_fall) begin
                m_boost = '0;
            end
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model on every falling edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 R7 latch", port_q, m_latch);
            chk("R2 drive_low", drive_low_en, ~m_latch);
            chk("R2 R6 weak", weak_pu_en, m_latch);
            chk("R3 R4 R5 strong", strong_pu_en, m_boost & m_latch);
            chk("R8 in_q", in_q, m_in);
            chk("R6 exclusive", drive_low_en & (weak_pu_en | strong_pu_en), '0);
        end
    end

    task automatic write_byte(input logic [W-1:0] b, input logic fall);
        @(negedge clk);
        wr_stb = 1'b1; wr_byte = b; scl_fall = fall;
        @(negedge clk);
        wr_stb = 1'b0; scl_fall = 1'b0;
    endtask

    task automatic fall_edge();
        @(negedge clk);
        scl_fall = 1'b1;
        @(negedge clk);
        scl_fall = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 latch", port_q, 8'hFF);
        chk("R1 weak", weak_pu_en, 8'hFF);
        chk("R1 low", drive_low_en, 8'h00);
        chk("R1 strong", strong_pu_en, 8'h00);
        chk("R1 in_q", in_q, 8'hFF);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);

        // R2 R3: write A5
        write_byte(8'hA5, 1'b0);
        chk("R2 latch", port_q, 8'hA5);
        chk("R2 low", drive_low_en, 8'h5A);
        chk("R3 strong", strong_pu_en, 8'hA5);
        // R7: idle keeps everything
        repeat (3) @(negedge clk);
        chk("R7 hold", port_q, 8'hA5);
        chk("R7 strong hold", strong_pu_en, 8'hA5);
        // R4: falling edge clears strong, keeps latch
        fall_edge();
        chk("R4 strong", strong_pu_en, 8'h00);
        chk("R4 latch", port_q, 8'hA5);
        // R3: all-zero write never arms
        write_byte(8'h00, 1'b0);
        chk("R3 zeros", strong_pu_en, 8'h00);
        chk("R6 low", drive_low_en, 8'hFF);
        // R5: write and falling edge together
        write_byte(8'h3C, 1'b1);
        chk("R5 strong", strong_pu_en, 8'h3C);
        fall_edge();
        // R3: rewriting ones over ones re-arms
        write_byte(8'hFF, 1'b0);
        fall_edge();
        write_byte(8'hFF, 1'b0);
        chk("R3 rearm", strong_pu_en, 8'hFF);

        // R8: pin change in the strobe cycle is not captured
        @(negedge clk);
        pin_lvl = 8'h96; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk("R8 latency", in_q, 8'hFF);
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk("R8 capture", in_q, 8'h96);
        pin_lvl = 8'h00;
        repeat (4) @(negedge clk);
        chk("R8 hold", in_q, 8'h96);

        // Mixed random traffic, including coincident strobes
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            wr_stb   = ($urandom_range(0, 3) == 0);
            scl_fall = ($urandom_range(0, 2) == 0);
            rd_stb   = ($urandom_range(0, 3) == 0);
            wr_byte  = W'($urandom);
            if ($urandom_range(0, 1) == 0) pin_lvl = W'($urandom);
        end
        @(negedge clk);
        wr_stb = 1'b0; scl_fall = 1'b0; rd_stb = 1'b0;

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 re-reset latch", port_q, 8'hFF);
        chk("R1 re-reset strong", strong_pu_en, 8'h00);
        repeat (2) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule